// File: doc/BRIEF.md
# Front-End Micro-Op Source Monitor

This block watches the instruction front end of a core and reports how well the decoded micro-op cache is serving it. Every cycle it takes in how many micro-ops each source delivered: the decoded cache, the legacy decoder, the microcode sequencer and an optional loop buffer. It also takes one-bit indications of unhalted core clocks and of cycles lost when delivery switches from the decoded cache to the legacy decoder. It accumulates all of these in saturating counters.

On a snapshot request the monitor freezes copies of the counters. It then runs one restoring divider twice, once per ratio, and produces two integer percentages. The first is switch-penalty cycles per unhalted cycle. The second is the decoded cache's share of all delivered micro-ops. A flag marks workloads that lean heavily on the decoded cache and are therefore sensitive to lost cache residency. A one-cycle done pulse closes each snapshot, and the results hold until the next snapshot completes.

Top module: `fe_uop_monitor`

## Requirements
- R1: The unhalted-cycle counter advances by one only in cycles where `unhalted` is 1. It holds its value otherwise.
- R2: `penalty_pct` equals floor(100 × penalty cycles / unhalted cycles), using the frozen counts. A result above 255 is clamped to 255.
- R3: `share_pct` equals floor(100 × decoded-cache micro-ops / (decoded-cache + legacy + sequencer + loop-buffer micro-ops)), using the frozen counts.
- R4: With `HAS_LOOP_BUF` = 0, the loop-buffer input is ignored and its term is absent from the share denominator.
- R5: After a snapshot, `reliance_hi` is 1 exactly when `share_pct` is strictly greater than `THRESH_PCT` (default 40). A share of exactly 40 gives 0.
- R6: A zero denominator gives a percentage of 0, and the matching div0 bit (`penalty_div0` or `share_div0`) is set to 1.
- R7: Every counter saturates at its all-ones value and never wraps.
- R8: A snapshot uses counter values frozen at the request. A `clr` or another `snap_req` during a snapshot changes neither its results nor its single one-cycle `done` pulse.
- R9: `clr` zeroes all six counters, so a later snapshot reports both div0 bits set to 1 and both percentages 0.
- R10: After reset, `busy`, `done`, both percentages, both div0 bits and `reliance_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous counter clear |
| unhalted | input | 1 | Core is in the active (unhalted) state this cycle |
| penalty_cyc | input | 1 | This cycle is a cache-to-legacy switch penalty cycle |
| dc_uops | input | INC_W | Micro-ops from the decoded cache this cycle (0..6) |
| leg_uops | input | INC_W | Micro-ops from the legacy decoder this cycle |
| ms_uops | input | INC_W | Micro-ops from the microcode sequencer this cycle |
| lb_uops | input | INC_W | Micro-ops from the loop buffer this cycle |
| snap_req | input | 1 | Start a snapshot (accepted only when idle) |
| busy | output | 1 | Snapshot in progress |
| done | output | 1 | One-cycle pulse when both results are valid |
| penalty_pct | output | 8 | Switch-penalty percentage |
| share_pct | output | 8 | Decoded-cache share percentage |
| penalty_div0 | output | 1 | Penalty ratio had a zero denominator |
| share_div0 | output | 1 | Share ratio had a zero denominator |
| reliance_hi | output | 1 | Share exceeds the reliance threshold |

## Verification
The in-line assertions check several properties on every cycle: counters never drop except through clear, and they stay at all-ones once saturated. The unhalted counter holds still while the core is halted. `done` never lasts two cycles. A div0 result always reads 0, and the reliance flag never stands beside a share at or below the threshold. The exact quotients can only be shown by the bench's scenarios. These include truncation, the 255 clamp, the 40 percent boundary, the effect of dropping the loop-buffer term, and saturation feeding a ratio. The same holds for freezing across a mid-snapshot clear and for the ignored second request.

// File: rtl/fe_mon_pkg.sv
package fe_mon_pkg;
  localparam int PCT_W    = 8;
  localparam int NSRC     = 6;
  localparam int IDX_CORE = 0;
  localparam int IDX_PEN  = 1;
  localparam int IDX_DC   = 2;
  localparam int IDX_LEG  = 3;
  localparam int IDX_MS   = 4;
  localparam int IDX_LB   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEN_GO,
    ST_PEN_RUN,
    ST_SHR_GO,
    ST_SHR_RUN
  } mon_state_e;
endpackage

// File: rtl/fe_sat_counter.sv
module fe_sat_counter #(
  parameter int CNT_W = 48,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, cnt} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (sum[CNT_W]) cnt <= '1;
    else                 cnt <= sum[CNT_W-1:0];
  end

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr) |=> (cnt >= $past(cnt)));
  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && !clr && cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/fe_restoring_div.sv
module fe_restoring_div #(
  parameter int NUM_W = 55,
  parameter int DEN_W = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo,
  output logic             div0
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W:0]   trial;
  logic [CNT_W-1:0] steps;
  logic             running;

  assign trial = {rem, quo[NUM_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0; quo <= '0; steps <= '0;
      running <= 1'b0; done <= 1'b0; div0 <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        rem <= '0;
        if (den == '0) begin
          quo  <= '0;
          div0 <= 1'b1;
          done <= 1'b1;
        end else begin
          quo     <= num;
          div0    <= 1'b0;
          steps   <= CNT_W'(NUM_W);
          running <= 1'b1;
        end
      end else if (running) begin
        if (trial >= {1'b0, den}) begin
          rem <= DEN_W'(trial - {1'b0, den});
          quo <= {quo[NUM_W-2:0], 1'b1};
        end else begin
          rem <= trial[DEN_W-1:0];
          quo <= {quo[NUM_W-2:0], 1'b0};
        end
        steps <= steps - 1'b1;
        if (steps == CNT_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assert_div0_quo_R6: assert property (@(posedge clk) disable iff (rst)
    (done && div0) |-> (quo == '0));
endmodule

// File: rtl/fe_uop_monitor.sv
module fe_uop_monitor
  import fe_mon_pkg::*;
#(
  parameter int CNT_W        = 48,
  parameter int INC_W        = 3,
  parameter bit HAS_LOOP_BUF = 1'b1,
  parameter int THRESH_PCT   = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             unhalted,
  input  logic             penalty_cyc,
  input  logic [INC_W-1:0] dc_uops,
  input  logic [INC_W-1:0] leg_uops,
  input  logic [INC_W-1:0] ms_uops,
  input  logic [INC_W-1:0] lb_uops,
  input  logic             snap_req,
  output logic             busy,
  output logic             done,
  output logic [PCT_W-1:0] penalty_pct,
  output logic [PCT_W-1:0] share_pct,
  output logic             penalty_div0,
  output logic             share_div0,
  output logic             reliance_hi
);
  localparam int NUM_W = CNT_W + 7;
  localparam int DEN_W = CNT_W + 2;
  localparam logic [NUM_W-1:0] PCT_MAX = NUM_W'((1 << PCT_W) - 1);

  logic [INC_W-1:0] inc_vec [NSRC];
  logic [CNT_W-1:0] cnt     [NSRC];
  logic [CNT_W-1:0] frz     [NSRC];

  assign inc_vec[IDX_CORE] = INC_W'(unhalted);
  assign inc_vec[IDX_PEN]  = INC_W'(penalty_cyc);
  assign inc_vec[IDX_DC]   = dc_uops;
  assign inc_vec[IDX_LEG]  = leg_uops;
  assign inc_vec[IDX_MS]   = ms_uops;
  assign inc_vec[IDX_LB]   = lb_uops;

  for (genvar g = 0; g < NSRC; g++) begin : g_cnt
    if (g == IDX_LB && !HAS_LOOP_BUF) begin : g_absent
      assign cnt[g] = '0;
    end else begin : g_present
      fe_sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .inc(inc_vec[g]), .cnt(cnt[g]));
    end
  end

  mon_state_e       st;
  logic             div_start, div_done, div_div0;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den, share_den;
  logic             pen_phase;
  logic [PCT_W-1:0] quo_clamped;

  assign share_den = DEN_W'(frz[IDX_DC]) + DEN_W'(frz[IDX_LEG])
                   + DEN_W'(frz[IDX_MS]) + DEN_W'(frz[IDX_LB]);
  assign pen_phase = (st == ST_PEN_GO) || (st == ST_PEN_RUN);
  assign div_start = (st == ST_PEN_GO) || (st == ST_SHR_GO);
  assign div_num   = (pen_phase ? NUM_W'(frz[IDX_PEN]) : NUM_W'(frz[IDX_DC])) * NUM_W'(100);
  assign div_den   = pen_phase ? DEN_W'(frz[IDX_CORE]) : share_den;
  assign quo_clamped = (div_quo > PCT_MAX) ? PCT_W'(PCT_MAX) : div_quo[PCT_W-1:0];
  assign busy = (st != ST_IDLE);

  fe_restoring_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_quo), .div0(div_div0));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; done <= 1'b0;
      penalty_pct <= '0; share_pct <= '0;
      penalty_div0 <= 1'b0; share_div0 <= 1'b0; reliance_hi <= 1'b0;
      for (int i = 0; i < NSRC; i++) frz[i] <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (snap_req) begin
          for (int i = 0; i < NSRC; i++) frz[i] <= cnt[i];
          st <= ST_PEN_GO;
        end
        ST_PEN_GO:  st <= ST_PEN_RUN;
        ST_PEN_RUN: if (div_done) begin
          penalty_pct  <= quo_clamped;
          penalty_div0 <= div_div0;
          st <= ST_SHR_GO;
        end
        ST_SHR_GO:  st <= ST_SHR_RUN;
        ST_SHR_RUN: if (div_done) begin
          share_pct   <= quo_clamped;
          share_div0  <= div_div0;
          reliance_hi <= !div_div0 && (quo_clamped > PCT_W'(THRESH_PCT));
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_core_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!rst && !unhalted && !clr) |=> $stable(cnt[IDX_CORE]));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_div0_zero_R6: assert property (@(posedge clk) disable iff (rst)
    share_div0 |-> (share_pct == '0));
  assert_reliance_thresh_R5: assert property (@(posedge clk) disable iff (rst)
    reliance_hi |-> (share_pct > PCT_W'(THRESH_PCT)));
endmodule

// File: tb/fe_uop_monitor_tb.sv
`timescale 1ns/1ps
module fe_uop_monitor_tb;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;
  // fields: n[23:16] unh_period[15:14] pen_period[13:12] dc[11:9] leg[8:6] ms[5:3] lb[2:0]
  localparam int NVEC = 8;
  localparam logic [23:0] VEC [0:NVEC-1] = '{
    {8'd20,  2'd1, 2'd1, 3'd2, 3'd1, 3'd1, 3'd0},
    {8'd30,  2'd1, 2'd3, 3'd1, 3'd2, 3'd0, 3'd1},
    {8'd20,  2'd1, 2'd2, 3'd2, 3'd3, 3'd0, 3'd0},
    {8'd21,  2'd1, 2'd3, 3'd3, 3'd4, 3'd0, 3'd0},
    {8'd24,  2'd3, 2'd1, 3'd2, 3'd1, 3'd0, 3'd2},
    {8'd60,  2'd1, 2'd1, 3'd6, 3'd1, 3'd0, 3'd0},
    {8'd20,  2'd0, 2'd1, 3'd0, 3'd0, 3'd0, 3'd0},
    {8'd255, 2'd1, 2'd3, 3'd0, 3'd0, 3'd5, 3'd0}
  };

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, unhalted = 1'b0, penalty_cyc = 1'b0, snap_req = 1'b0;
  logic [2:0] dc_uops = '0, leg_uops = '0, ms_uops = '0, lb_uops = '0;
  logic busy, done, pdz, sdz, rel;
  logic [7:0] ppct, spct;
  logic busy_n, done_n, pdz_n, sdz_n, rel_n;
  logic [7:0] ppct_n, spct_n;

  int checks = 0, failures = 0, cycles = 0;
  int e_core, e_pen, e_dc, e_leg, e_ms, e_lb;

  always #2 clk = ~clk;

  fe_uop_monitor #(.CNT_W(CW), .INC_W(3), .HAS_LOOP_BUF(1'b1)) u_dut (
    .clk(clk), .rst(rst), .clr(clr), .unhalted(unhalted), .penalty_cyc(penalty_cyc),
    .dc_uops(dc_uops), .leg_uops(leg_uops), .ms_uops(ms_uops), .lb_uops(lb_uops),
    .snap_req(snap_req), .busy(busy), .done(done), .penalty_pct(ppct), .share_pct(spct),
    .penalty_div0(pdz), .share_div0(sdz), .reliance_hi(rel));

  fe_uop_monitor #(.CNT_W(CW), .INC_W(3), .HAS_LOOP_BUF(1'b0)) u_dut_nl (
    .clk(clk), .rst(rst), .clr(clr), .unhalted(unhalted), .penalty_cyc(penalty_cyc),
    .dc_uops(dc_uops), .leg_uops(leg_uops), .ms_uops(ms_uops), .lb_uops(lb_uops),
    .snap_req(snap_req), .busy(busy_n), .done(done_n), .penalty_pct(ppct_n), .share_pct(spct_n),
    .penalty_div0(pdz_n), .share_div0(sdz_n), .reliance_hi(rel_n));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int pct(input int n, input int d);
    int q;
    if (d == 0) return 0;
    q = (100 * n) / d;
    return (q > 255) ? 255 : q;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic clear_counters();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    e_core = 0; e_pen = 0; e_dc = 0; e_leg = 0; e_ms = 0; e_lb = 0;
  endtask

  task automatic drive_vec(input int idx);
    logic [23:0] v;
    int n, up, pp;
    v = VEC[idx];
    n = int'(v[23:16]); up = int'(v[15:14]); pp = int'(v[13:12]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      unhalted    = (up != 0) && (i % (up == 0 ? 1 : up) == 0);
      penalty_cyc = (pp != 0) && (i % (pp == 0 ? 1 : pp) == 0);
      dc_uops = v[11:9]; leg_uops = v[8:6]; ms_uops = v[5:3]; lb_uops = v[2:0];
      e_core = sat(e_core + int'(unhalted)); e_pen = sat(e_pen + int'(penalty_cyc));
      e_dc = sat(e_dc + int'(dc_uops)); e_leg = sat(e_leg + int'(leg_uops));
      e_ms = sat(e_ms + int'(ms_uops)); e_lb = sat(e_lb + int'(lb_uops));
    end
    @(negedge clk);
    unhalted = 1'b0; penalty_cyc = 1'b0;
    dc_uops = '0; leg_uops = '0; ms_uops = '0; lb_uops = '0;
  endtask

  task automatic wait_done(output int ndone);
    bit seen_a = 0, seen_b = 0;
    ndone = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin seen_a = 1; ndone++; end
      if (done_n) seen_b = 1;
      if (seen_a && seen_b && i > 150) break;
    end
    chk("R8 snapshot completes", int'(seen_a && seen_b), 1);
  endtask

  task automatic snapshot();
    int nd;
    @(negedge clk) snap_req = 1'b1;
    @(negedge clk) snap_req = 1'b0;
    wait_done(nd);
  endtask

  task automatic check_results(input string tag);
    int den_a, den_b, sa, sb;
    den_a = e_dc + e_leg + e_ms + e_lb;
    den_b = e_dc + e_leg + e_ms;
    sa = pct(e_dc, den_a); sb = pct(e_dc, den_b);
    chk({"R2 penalty_pct ", tag}, int'(ppct), pct(e_pen, e_core));
    chk({"R6 penalty_div0 ", tag}, int'(pdz), int'(e_core == 0));
    chk({"R3 share_pct ", tag}, int'(spct), sa);
    chk({"R6 share_div0 ", tag}, int'(sdz), int'(den_a == 0));
    chk({"R5 reliance_hi ", tag}, int'(rel), int'(den_a != 0 && sa > 40));
    chk({"R4 share_pct no-loop ", tag}, int'(spct_n), sb);
    chk({"R4 reliance no-loop ", tag}, int'(rel_n), int'(den_b != 0 && sb > 40));
    chk({"R2 penalty no-loop ", tag}, int'(ppct_n), pct(e_pen, e_core));
  endtask

  initial begin
    int nd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 pcts", int'(ppct) + int'(spct), 0);
    chk("R10 flags", int'(pdz) + int'(sdz) + int'(rel), 0);

    // Vector table: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      clear_counters();
      drive_vec(k);
      snapshot();
      check_results($sformatf("vec%0d", k));
    end

    // R8: clear and second request during a snapshot
    clear_counters();
    drive_vec(0);
    @(negedge clk) snap_req = 1'b1;
    @(negedge clk) snap_req = 1'b0; clr = 1'b1;
    chk("R8 busy after request", int'(busy), 1);
    @(negedge clk) clr = 1'b0; snap_req = 1'b1;
    @(negedge clk) snap_req = 1'b0;
    wait_done(nd);
    chk("R8 single done pulse", nd, 1);
    check_results("R8 frozen");
    repeat (150) @(negedge clk);
    chk("R8 second request ignored", int'(busy), 0);

    // R9: counters were cleared mid-snapshot
    e_core = 0; e_pen = 0; e_dc = 0; e_leg = 0; e_ms = 0; e_lb = 0;
    snapshot();
    chk("R9 penalty_div0 after clr", int'(pdz), 1);
    chk("R9 share_div0 after clr", int'(sdz), 1);
    chk("R9 pcts after clr", int'(ppct) + int'(spct), 0);
    check_results("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule